// File: doc/BRIEF.md
# Router Test Wrapper Configuration Decoder

This block is the synchronous control module of one router test wrapper. A two-bit configuration chain passes through it, and several wrappers are wired in series, each one's chain output feeding the next one's chain input. Configuration frames of 26 bits travel the chain, two bits per step and most significant bits first. Each frame carries an end-of-frame marker, a 3-bit wrapper identifier, a bypass request and one control field per router port.

The decoder keeps a sliding window of the last 13 steps and a step counter that marks frame boundaries from reset. When a frame is complete, its marker is nonzero and its identifier equals the wrapper's own fixed identifier (parameter `WRAP_ID`), the decoder loads the port settings into shadow registers in one cycle. Those registers drive the mode and select lines of five input test cells and five output test cells, plus a bypass enable. The matching frame is then consumed and replaced downstream by an all-zero null frame. Every other frame leaves unchanged, exactly one frame slot later.

The chain uses valid/ready in lock step. A step happens only when the upstream side offers data (`cfg_in_valid`) and the downstream side accepts (`cfg_out_ready`). The block adds no buffering: its ready follows the downstream ready, and its output valid follows the input valid. Back-pressure therefore propagates through the whole chain combinationally, and a stall freezes every wrapper's window and counter.

Top module: `cfg_frame_decoder`

## Requirements
- R1: While `rst` is high (synchronous, active high), the next clock edge clears every cell mode and select and the bypass enable, and `cfg_in_ready` and `cfg_out_valid` are low.
- R2: A chain step happens only at a clock edge where `cfg_in_valid` and `cfg_out_ready` are both high; `cfg_in_ready` equals `cfg_out_ready` and `cfg_out_valid` equals `cfg_in_valid` outside reset; with no step, neither the control outputs nor `cfg_out_data` change.
- R3: A frame is 13 steps; the step counter starts at reset, and the first step of each frame carries frame bits [25:24], the last step bits [1:0].
- R4: Frame fields: [25:24] end-of-frame marker, [23:21] wrapper identifier, [20] bypass request, and port p (0 North, 1 East, 2 South, 3 West, 4 Local) at [4p+3:4p] as {output-cell mode, output-cell select, input-cell mode, input-cell select}.
- R5: A complete frame with a nonzero marker and an identifier equal to `WRAP_ID` updates the control outputs at the clock edge of its 13th step.
- R6: The control outputs do not change during shifting, nor for a frame whose marker is zero or whose identifier differs.
- R7: `cfg_out_data` presents the chain input delayed by exactly 13 steps, so a non-matching frame leaves unchanged in the following frame slot.
- R8: A matching frame is consumed: in its slot downstream the chain carries an all-zero frame.
- R9: A loaded frame with the bypass request set drives `bypass_en` high and every cell mode and select low, regardless of the port fields.
- R10: A cell select loads as 1 only when the same cell's mode bit is 1 (mode 1 = test, select 1 = local test path); a cell in normal mode always selects the network path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_valid | input | 1 | Upstream offers a chain step |
| cfg_in_ready | output | 1 | Wrapper accepts a chain step |
| cfg_in_data | input | 2 | Chain input bits |
| cfg_out_valid | output | 1 | Chain output offers a step |
| cfg_out_ready | input | 1 | Downstream accepts a step |
| cfg_out_data | output | 2 | Chain output bits (oldest two bits of the window) |
| itc_mode | output | 5 | Input test cell mode per port, 1 = test |
| itc_sel | output | 5 | Input test cell select per port, 1 = local path |
| otc_mode | output | 5 | Output test cell mode per port, 1 = test |
| otc_sel | output | 5 | Output test cell select per port, 1 = local path |
| bypass_en | output | 1 | Route traffic around the router |

## Verification
The assertions check four properties on every cycle: control outputs and chain output hold still when no handshake completes, bypass excludes any test mode, and no select is set for a cell in normal mode. Only the bench's scenarios can show that frames are decoded at the right step with the field positions given, that identifier and marker filtering pick the right frames, and that the 13-step forwarding delay and frame consumption hold across a two-wrapper chain under random stalls on both sides.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int NPORT = 5;      // router ports: N, E, S, W, local
  localparam int PORT_FW = 4;    // bits per port field

  typedef struct packed {
    logic             bypass;
    logic [NPORT-1:0] otc_mode;
    logic [NPORT-1:0] otc_sel;
    logic [NPORT-1:0] itc_mode;
    logic [NPORT-1:0] itc_sel;
  } cell_ctrl_t;
endpackage

// File: rtl/cfgdec_shift.sv
module cfgdec_shift #(
  parameter int FRAME_W = 26,
  parameter int CHAIN_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               consume,
  input  logic [CHAIN_W-1:0] din,
  output logic [CHAIN_W-1:0] dout,
  output logic [FRAME_W-1:0] window_next,
  output logic               last_step
);
  localparam int STEPS = FRAME_W / CHAIN_W;
  localparam int CNT_W = $clog2(STEPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic [FRAME_W-1:0] window_q;
  logic [CNT_W-1:0]   cnt_q;

  assign window_next = {window_q[FRAME_W-CHAIN_W-1:0], din};
  assign dout        = window_q[FRAME_W-1 -: CHAIN_W];
  assign last_step   = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      window_q <= '0;
      cnt_q    <= '0;
    end else if (step) begin
      window_q <= consume ? '0 : window_next;
      cnt_q    <= last_step ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfgdec_decode.sv
module cfgdec_decode
  import cfgdec_pkg::*;
#(
  parameter int          FRAME_W = 26,
  parameter int          EOF_W   = 2,
  parameter int          ID_W    = 3,
  parameter int unsigned WRAP_ID = 0
) (
  input  logic [FRAME_W-1:0] frame,
  output logic               hit,
  output cell_ctrl_t         ctrl
);
  localparam int BYP_POS = NPORT * PORT_FW;

  logic [EOF_W-1:0] eof_f;
  logic [ID_W-1:0]  id_f;
  logic             byp_f;
  cell_ctrl_t       raw;

  assign eof_f = frame[FRAME_W-1 -: EOF_W];
  assign id_f  = frame[FRAME_W-EOF_W-1 -: ID_W];
  assign byp_f = frame[BYP_POS];
  assign hit   = (eof_f != '0) && (id_f == ID_W'(WRAP_ID));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [PORT_FW-1:0] fld;
    assign fld            = frame[p*PORT_FW +: PORT_FW];
    assign raw.otc_mode[p] = fld[3];
    assign raw.otc_sel[p]  = fld[3] & fld[2];
    assign raw.itc_mode[p] = fld[1];
    assign raw.itc_sel[p]  = fld[1] & fld[0];
  end
  assign raw.bypass = byp_f;

  always_comb begin
    ctrl = raw;
    if (byp_f) begin
      ctrl          = '0;
      ctrl.bypass   = 1'b1;
    end
  end
endmodule

// File: rtl/cfgdec_shadow.sv
module cfgdec_shadow
  import cfgdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  cell_ctrl_t ctrl_d,
  output cell_ctrl_t ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)       ctrl_q <= '0;
    else if (load) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/cfg_frame_decoder.sv
module cfg_frame_decoder
  import cfgdec_pkg::*;
#(
  parameter int unsigned WRAP_ID = 0,
  parameter int          ID_W    = 3,
  parameter int          EOF_W   = 2,
  parameter int          CHAIN_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_in_valid,
  output logic               cfg_in_ready,
  input  logic [CHAIN_W-1:0] cfg_in_data,
  output logic               cfg_out_valid,
  input  logic               cfg_out_ready,
  output logic [CHAIN_W-1:0] cfg_out_data,
  output logic [NPORT-1:0]   itc_mode,
  output logic [NPORT-1:0]   itc_sel,
  output logic [NPORT-1:0]   otc_mode,
  output logic [NPORT-1:0]   otc_sel,
  output logic               bypass_en
);
  localparam int FRAME_W = EOF_W + ID_W + 1 + NPORT * PORT_FW;

  logic               step;
  logic               last_step;
  logic               hit;
  logic               load;
  logic [FRAME_W-1:0] window_next;
  cell_ctrl_t         ctrl_dec;
  cell_ctrl_t         ctrl_q;

  assign cfg_in_ready  = cfg_out_ready & ~rst;
  assign cfg_out_valid = cfg_in_valid & ~rst;
  assign step          = cfg_in_valid & cfg_in_ready;
  assign load          = step & last_step & hit;

  cfgdec_shift #(.FRAME_W(FRAME_W), .CHAIN_W(CHAIN_W)) u_shift (
    .clk(clk), .rst(rst), .step(step), .consume(load), .din(cfg_in_data),
    .dout(cfg_out_data), .window_next(window_next), .last_step(last_step)
  );

  cfgdec_decode #(.FRAME_W(FRAME_W), .EOF_W(EOF_W), .ID_W(ID_W), .WRAP_ID(WRAP_ID)) u_dec (
    .frame(window_next), .hit(hit), .ctrl(ctrl_dec)
  );

  cfgdec_shadow u_shadow (
    .clk(clk), .rst(rst), .load(load), .ctrl_d(ctrl_dec), .ctrl_q(ctrl_q)
  );

  assign itc_mode  = ctrl_q.itc_mode;
  assign itc_sel   = ctrl_q.itc_sel;
  assign otc_mode  = ctrl_q.otc_mode;
  assign otc_sel   = ctrl_q.otc_sel;
  assign bypass_en = ctrl_q.bypass;
endmodule

// File: rtl/cfgdec_chk.sv
module cfgdec_chk
  import cfgdec_pkg::*;
#(
  parameter int CHAIN_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_in_valid,
  input logic               cfg_in_ready,
  input logic [CHAIN_W-1:0] cfg_out_data,
  input logic [NPORT-1:0]   itc_mode,
  input logic [NPORT-1:0]   itc_sel,
  input logic [NPORT-1:0]   otc_mode,
  input logic [NPORT-1:0]   otc_sel,
  input logic               bypass_en
);
  logic [4*NPORT:0] bundle;
  assign bundle = {bypass_en, otc_mode, otc_sel, itc_mode, itc_sel};

  AST_CTRL_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(cfg_in_valid && cfg_in_ready) |=> $stable(bundle)); // R6

  AST_OUT_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    !(cfg_in_valid && cfg_in_ready) |=> $stable(cfg_out_data)); // R2

  AST_BYPASS_NO_TEST: assert property (@(posedge clk) disable iff (rst)
    bypass_en |-> (itc_mode == '0 && otc_mode == '0 && itc_sel == '0 && otc_sel == '0)); // R9

  AST_SEL_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    ((itc_sel & ~itc_mode) == '0) && ((otc_sel & ~otc_mode) == '0)); // R10
endmodule

bind cfg_frame_decoder cfgdec_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_in_valid(cfg_in_valid), .cfg_in_ready(cfg_in_ready),
  .cfg_out_data(cfg_out_data), .itc_mode(itc_mode), .itc_sel(itc_sel),
  .otc_mode(otc_mode), .otc_sel(otc_sel), .bypass_en(bypass_en)
);

// File: tb/tb_cfg_frame_decoder.sv
module tb_cfg_frame_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       in_valid = 1'b0;
  logic [1:0] in_data  = 2'b00;
  logic       end_ready = 1'b1;

  logic       a_in_ready, a_out_valid, a_b_ready;
  logic [1:0] a_out_data;
  logic [4:0] a_im, a_is, a_om, a_os;
  logic       a_byp;
  logic       b_out_valid, b_in_ready;
  logic [1:0] b_out_data;
  logic [4:0] b_im, b_is, b_om, b_os;
  logic       b_byp;

  assign a_b_ready = b_in_ready;

  cfg_frame_decoder #(.WRAP_ID(5)) dut (
    .clk(clk), .rst(rst), .cfg_in_valid(in_valid), .cfg_in_ready(a_in_ready),
    .cfg_in_data(in_data), .cfg_out_valid(a_out_valid), .cfg_out_ready(a_b_ready),
    .cfg_out_data(a_out_data), .itc_mode(a_im), .itc_sel(a_is), .otc_mode(a_om),
    .otc_sel(a_os), .bypass_en(a_byp)
  );

  cfg_frame_decoder #(.WRAP_ID(2)) u_next (
    .clk(clk), .rst(rst), .cfg_in_valid(a_out_valid), .cfg_in_ready(b_in_ready),
    .cfg_in_data(a_out_data), .cfg_out_valid(b_out_valid), .cfg_out_ready(end_ready),
    .cfg_out_data(b_out_data), .itc_mode(b_im), .itc_sel(b_is), .otc_mode(b_om),
    .otc_sel(b_os), .bypass_en(b_byp)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [20:0] exp_a = '0, exp_b = '0;
  logic [25:0] fwd_prev = '0;   // what dut emits during the current frame slot
  logic [25:0] fwd2_prev = '0;  // what u_next emits during the current slot
  logic [25:0] cap_a, cap_b;

  function automatic logic [20:0] model(input logic [25:0] f);
    logic [4:0] om, os, im, is_;
    for (int p = 0; p < 5; p++) begin
      om[p]  = f[4*p+3];
      os[p]  = f[4*p+3] & f[4*p+2];
      im[p]  = f[4*p+1];
      is_[p] = f[4*p+1] & f[4*p];
    end
    if (f[20]) return {1'b1, 20'b0};
    return {1'b0, om, os, im, is_};
  endfunction

  function automatic bit hits(input logic [25:0] f, input int id);
    return (f[25:24] != 2'b00) && (f[23:21] == 3'(id));
  endfunction

  function automatic logic [20:0] obs_a();
    return {a_byp, a_om, a_os, a_im, a_is};
  endfunction
  function automatic logic [20:0] obs_b();
    return {b_byp, b_om, b_os, b_im, b_is};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Shift one frame through the chain, MSB pair first, with optional random stalls.
  task automatic send_frame(input logic [25:0] f, input bit stalls);
    logic [20:0] before_a;
    logic [1:0]  hold_b;
    before_a = obs_a();
    for (int k = 0; k < 13; k++) begin
      if (stalls && ($urandom % 3 == 0)) begin
        @(negedge clk);
        if ($urandom % 2 == 0) begin in_valid = 1'b0; end_ready = 1'b1; end
        else begin in_valid = 1'b1; end_ready = 1'b0; in_data = ~f[25-2*k -: 2]; end
        #1;
        hold_b = b_out_data;
        if (!end_ready) chk("R2 ready follows downstream", {31'b0, a_in_ready}, 32'd0);
        @(negedge clk);
        #1;
        chk("R2 stall keeps controls", {11'b0, obs_a()}, {11'b0, before_a});
        chk("R2 stall keeps chain output", {30'b0, b_out_data}, {30'b0, hold_b});
      end
      @(negedge clk);
      in_valid = 1'b1; end_ready = 1'b1; in_data = f[25-2*k -: 2];
      #1;
      chk("R2 output valid follows input", {31'b0, b_out_valid}, 32'd1);
      cap_a[25-2*k -: 2] = a_out_data;
      cap_b[25-2*k -: 2] = b_out_data;
      if (k == 12) chk("R6 no change while shifting", {11'b0, obs_a()}, {11'b0, before_a});
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic run_frame(input logic [25:0] f, input bit stalls, input string tag);
    logic [25:0] fwd;
    send_frame(f, stalls);
    // dut sees f now; u_next sees what dut forwarded in this slot
    if (hits(f, 5)) exp_a = model(f);
    if (hits(fwd_prev, 2)) exp_b = model(fwd_prev);
    chk({tag, " R5 R6 dut controls"}, {11'b0, obs_a()}, {11'b0, exp_a});
    chk({tag, " R5 R6 downstream controls"}, {11'b0, obs_b()}, {11'b0, exp_b});
    chk({tag, " R7 R8 dut chain output"}, {6'b0, cap_a}, {6'b0, fwd_prev});
    chk({tag, " R7 R8 downstream chain output"}, {6'b0, cap_b}, {6'b0, fwd2_prev});
    fwd = hits(f, 5) ? 26'b0 : f;
    fwd2_prev = hits(fwd_prev, 2) ? 26'b0 : fwd_prev;
    fwd_prev = fwd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [25:0] f;
    int r;
    void'($urandom(32'd20240611));
    in_valid = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset controls", {11'b0, obs_a()}, 32'd0);
    chk("R1 reset ready", {31'b0, a_in_ready}, 32'd0);
    chk("R1 reset out valid", {31'b0, a_out_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;

    // Directed: matching frame, all port fields set (R3 R4 R5 R10)
    run_frame({2'b01, 3'd5, 1'b0, 20'hFFFFF}, 0, "match-ones");
    // R4 field layout: North otc mode only, Local itc mode+sel, East itc sel without mode
    run_frame({2'b11, 3'd5, 1'b0, 4'b0011, 4'b0000, 4'b0000, 4'b0001, 4'b1000}, 0, "R4 layout");
    chk("R4 north otc mode", {27'b0, a_om}, 32'h01);
    chk("R10 east sel w/o mode", {27'b0, a_is}, 32'h10);
    // Null marker with own ID is ignored
    run_frame({2'b00, 3'd5, 1'b0, 20'hAAAAA}, 0, "R6 null-marker");
    // Frame for the downstream wrapper passes through
    run_frame({2'b10, 3'd2, 1'b0, 20'h5A5A5}, 0, "R7 for-next");
    // Bypass request (R9)
    run_frame({2'b01, 3'd5, 1'b1, 20'hFFFFF}, 0, "R9 bypass");
    chk("R9 bypass set", {31'b0, a_byp}, 32'd1);
    // Non-matching ID
    run_frame({2'b01, 3'd7, 1'b0, 20'h12345}, 0, "R6 other-id");

    // Random frames with stalls on both sides
    for (int i = 0; i < 60; i++) begin
      f = 26'($urandom);
      r = int'($urandom % 4);
      if (r == 0) f[23:21] = 3'd5;
      else if (r == 1) f[23:21] = 3'd2;
      if ($urandom % 8 == 0) f[25:24] = 2'b00;
      else if (f[25:24] == 2'b00) f[25:24] = 2'b01;
      f[20] = ($urandom % 6 == 0);
      run_frame(f, 1, "random");
    end
    // Flush with null frames
    run_frame('0, 0, "flush");
    run_frame('0, 0, "flush");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule